// File: doc/BRIEF.md
# Sequential Integer Multiplier with Condition Flags

This block multiplies two 32-bit integers, treating them either as two's-complement or as unsigned values. It returns one of two result forms. The short form keeps only the low 32 bits of the product. The long form keeps all 64 bits, split into a low word and a high word. For each result it also produces negative, zero, overflow and carry flags, and which flags are set depends on the result form.

The product is built by a radix-2 shift-add engine that runs for one cycle per operand bit. In signed mode it multiplies the operand magnitudes and then applies a sign correction.

Operands enter on a valid/ready handshake:
- An operation is accepted on a rising edge where `start_valid` and `start_ready` are both high.
- `start_ready` stays low from acceptance until the result appears. A request made while `start_ready` is low is simply not taken, and the requester keeps `start_valid` high until it is.
- The result side has no back-pressure. The destination must capture the words on the cycle `done` is high. The result registers then hold their values until the next result.

Top module: `mulf_top`

## Requirements
- R1: After reset, `start_ready` is 1, and `done`, `lo_we`, `hi_we`, all four flags and both result words are 0.
- R2: An operation is accepted only on an edge with `start_valid` and `start_ready` both high. `start_ready` is 0 from the accepting edge until `done` is raised, and requests made while it is 0 produce no result.
- R3: `done` rises exactly 33 clock edges after the accepting edge and stays high for a single cycle. `start_ready` returns to 1 in that same cycle.
- R4: Bit 10 of `ctrl_word` set selects the long form. Then `lo_word` carries product bits 31..0, `hi_word` carries bits 63..32, and both `lo_we` and `hi_we` pulse with `done`. In the short form only `lo_we` pulses.
- R5: Bit 11 of `ctrl_word` set makes both operands two's-complement; clear makes them unsigned.
- R6: In the long form, Z is set exactly when all 64 product bits are zero, N equals product bit 63, and V is 0.
- R7: In the unsigned short form with `ovf_en` high, V is set when any of product bits 63..32 is nonzero.
- R8: In the signed short form with `ovf_en` high, V is set when the 64-bit product differs from the sign extension of its low 32 bits.
- R9: In the short form, Z and N are judged on the low 32 bits of the product only.
- R10: With `ovf_en` low in the short form, V is 0, and `lo_word` is the same for signed and unsigned operands.
- R11: C is 0 after every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Operation request |
| start_ready | output | 1 | Engine idle, request can be accepted |
| ctrl_word | input | 16 | Control word; bit 10 long form, bit 11 signed |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| ovf_en | input | 1 | Enables overflow reporting in the short form |
| done | output | 1 | One-cycle result strobe |
| lo_word | output | 32 | Low result word |
| lo_we | output | 1 | Write enable for the low destination |
| hi_word | output | 32 | High result word (long form) |
| hi_we | output | 1 | Write enable for the high destination |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest situation to reach from the ports is a request that arrives while the engine is busy. To test it, the stimulus holds `start_valid` high with different operands for many cycles in the middle of a multiplication. The scoreboard must then see exactly one result, and it must belong to the original operands.

The sign-correction corner cases are also deliberate:
- the most negative operand multiplied by itself and by minus one;
- a zero operand paired with a negative one;
- products whose low word is zero while the upper bits are not.

These separate the short-form and long-form Z and V rules.

// File: rtl/mulf_pkg.sv
package mulf_pkg;

  localparam int unsigned MUL_W    = 32;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned QUAD_POS = 10;
  localparam int unsigned SIGN_POS = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mulf_state_e;

  typedef struct packed {
    logic quad;
    logic sgn;
    logic ovf;
  } mulf_mode_t;

endpackage

// File: rtl/mulf_ctrl.sv
module mulf_ctrl
  import mulf_pkg::*;
#(
  parameter int unsigned W = MUL_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  input  mulf_mode_t mode_in,
  output logic       start_ready,
  output logic       load,
  output logic       step,
  output logic       fin,
  output mulf_mode_t mode_q
);

  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  mulf_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign start_ready = (state_q == ST_IDLE);
  assign load        = start_ready && start_valid;
  assign step        = (state_q == ST_RUN);
  assign fin         = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_valid) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        cnt_q  <= '0;
        mode_q <= mode_in;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready); // R2

  AST_FIN_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(step)); // R3

endmodule

// File: rtl/mulf_datapath.sv
module mulf_datapath
  import mulf_pkg::*;
#(
  parameter int unsigned W = MUL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           sgn_in,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [2*W-1:0] product
);

  localparam int unsigned PW = 2 * W;

  logic [W-1:0] mcand_q, hi_q, lo_q;
  logic         neg_q;
  logic [W-1:0] mag_a, mag_b;
  logic [W:0]   partial;
  logic [PW-1:0] raw;

  // Magnitudes of the operands (a signed operand is negated when its top bit is set)
  assign mag_a = (sgn_in && opa[W-1]) ? (~opa + 1'b1) : opa;
  assign mag_b = (sgn_in && opb[W-1]) ? (~opb + 1'b1) : opb;

  assign partial = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      neg_q   <= 1'b0;
    end else if (load) begin
      mcand_q <= mag_a;
      hi_q    <= '0;
      lo_q    <= mag_b;
      neg_q   <= sgn_in && (opa[W-1] ^ opb[W-1]);
    end else if (step) begin
      hi_q <= partial[W:1];
      lo_q <= {partial[0], lo_q[W-1:1]};
    end
  end

  assign raw     = {hi_q, lo_q};
  assign product = neg_q ? (~raw + 1'b1) : raw;

endmodule

// File: rtl/mulf_flags.sv
module mulf_flags
  import mulf_pkg::*;
#(
  parameter int unsigned W = MUL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fin,
  input  mulf_mode_t     mode,
  input  logic [2*W-1:0] product,
  output logic           done,
  output logic [W-1:0]   lo_word,
  output logic           lo_we,
  output logic [W-1:0]   hi_word,
  output logic           hi_we,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_v,
  output logic           flag_c
);

  logic [W-1:0] low_part, up_part;
  logic         ovf_short, n_d, z_d, v_d;

  assign low_part = product[W-1:0];
  assign up_part  = product[2*W-1:W];

  // Short-form overflow: the upper half carries more than the sign/zero extension
  assign ovf_short = mode.sgn ? (up_part != {W{low_part[W-1]}}) : (|up_part);

  always_comb begin
    if (mode.quad) begin
      n_d = product[2*W-1];
      z_d = (product == '0);
      v_d = 1'b0;
    end else begin
      n_d = low_part[W-1];
      z_d = (low_part == '0);
      v_d = mode.ovf && ovf_short;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      lo_we   <= 1'b0;
      hi_we   <= 1'b0;
      lo_word <= '0;
      hi_word <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
    end else begin
      done  <= fin;
      lo_we <= fin;
      hi_we <= fin && mode.quad;
      if (fin) begin
        lo_word <= low_part;
        if (mode.quad) hi_word <= up_part;
        flag_n <= n_d;
        flag_z <= z_d;
        flag_v <= v_d;
        flag_c <= 1'b0;
      end
    end
  end

  AST_WIDE_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hi_we) |-> !flag_v); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode.ovf) |-> !flag_v); // R10

  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hi_we) |-> (flag_z == (lo_word == '0))); // R9

endmodule

// File: rtl/mulf_top.sv
module mulf_top
  import mulf_pkg::*;
#(
  parameter int unsigned W = MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  input  logic              ovf_en,
  output logic              done,
  output logic [W-1:0]      lo_word,
  output logic              lo_we,
  output logic [W-1:0]      hi_word,
  output logic              hi_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  mulf_mode_t     mode_in, mode_q;
  logic           load, step, fin;
  logic [2*W-1:0] product;
  logic           ctrl_unused;

  assign mode_in.quad = ctrl_word[QUAD_POS];
  assign mode_in.sgn  = ctrl_word[SIGN_POS];
  assign mode_in.ovf  = ovf_en;
  assign ctrl_unused  = ^{ctrl_word[CTRL_W-1:SIGN_POS+1], ctrl_word[QUAD_POS-1:0]};

  mulf_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .mode_in     (mode_in),
    .start_ready (start_ready),
    .load        (load),
    .step        (step),
    .fin         (fin),
    .mode_q      (mode_q)
  );

  mulf_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .sgn_in  (mode_in.sgn),
    .opa     (src_a),
    .opb     (src_b),
    .product (product)
  );

  mulf_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin     (fin),
    .mode    (mode_q),
    .product (product),
    .done    (done),
    .lo_word (lo_word),
    .lo_we   (lo_we),
    .hi_word (hi_word),
    .hi_we   (hi_we),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .flag_c  (flag_c)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_HI_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |-> (done && lo_we)); // R4

endmodule

// File: tb/mulf_top_test.sv
module mulf_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] ctrl_word = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        ovf_en = 1'b0;
  logic        done, lo_we, hi_we, flag_n, flag_z, flag_v, flag_c;
  logic [31:0] lo_word, hi_word;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] last_lo = '0;

  typedef struct {
    logic        quad, sgn, ovf;
    logic [31:0] lo, hi;
    logic        n, z, v;
    int          due;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mulf_top uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .ctrl_word(ctrl_word), .src_a(src_a), .src_b(src_b), .ovf_en(ovf_en),
    .done(done), .lo_word(lo_word), .lo_we(lo_we), .hi_word(hi_word), .hi_we(hi_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic quad, input logic sgn, input logic ovf,
                                 input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [63:0] full;
    logic signed [63:0] sa, sb2;
    sa  = {{32{a[31]}}, a};
    sb2 = {{32{b[31]}}, b};
    if (sgn) full = sa * sb2;
    else     full = {32'b0, a} * {32'b0, b};
    e.quad = quad; e.sgn = sgn; e.ovf = ovf;
    e.lo = full[31:0]; e.hi = full[63:32];
    if (quad) begin
      e.z = (full == 64'd0); e.n = full[63]; e.v = 1'b0;
    end else begin
      e.z = (full[31:0] == 32'd0); e.n = full[31];
      e.v = ovf && (sgn ? (full[63:32] != {32{full[31]}}) : (full[63:32] != 32'd0));
    end
    e.due = 0;
    return e;
  endfunction

  // Driver: offers one operation, pushes its expectation, optionally harasses while busy
  task automatic run_op(input logic quad, input logic sgn, input logic ovf,
                        input logic [31:0] a, input logic [31:0] b, input bit harass);
    exp_t e;
    e = model(quad, sgn, ovf, a, b);
    @(negedge clk);
    ctrl_word = '0;
    ctrl_word[10] = quad;
    ctrl_word[11] = sgn;
    ovf_en = ovf; src_a = a; src_b = b; start_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e.due = cyc + 33;
    sb.push_back(e);
    chk("R2", "start_ready after accept", {31'b0, start_ready}, 32'd0);
    if (harass) begin
      src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678;
      ctrl_word[10] = ~quad; ovf_en = ~ovf;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        chk("R2", "start_ready while busy", {31'b0, start_ready}, 32'd0);
      end
    end
    start_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    exp_t e;
    string vreq;
    if (rst_n) begin
      if (done && prev_done) begin
        errors++; checks++;
        $display("FAIL R3 done held: actual=2 cycles expected=1");
      end
      if (done && !prev_done) begin
        if (sb.size() == 0) begin
          errors++; checks++;
          $display("FAIL R2 unexpected result: actual=done expected=no done");
        end else begin
          e = sb.pop_front();
          chk("R3", "done cycle", cyc, e.due);
          chk("R3", "start_ready with done", {31'b0, start_ready}, 32'd1);
          chk(e.sgn ? "R5" : "R4", "lo_word", lo_word, e.lo);
          chk("R4", "lo_we", {31'b0, lo_we}, 32'd1);
          chk("R4", "hi_we", {31'b0, hi_we}, {31'b0, e.quad});
          if (e.quad) chk("R4", "hi_word", hi_word, e.hi);
          chk(e.quad ? "R6" : "R9", "flag_n", {31'b0, flag_n}, {31'b0, e.n});
          chk(e.quad ? "R6" : "R9", "flag_z", {31'b0, flag_z}, {31'b0, e.z});
          vreq = e.quad ? "R6" : (!e.ovf ? "R10" : (e.sgn ? "R8" : "R7"));
          chk(vreq, "flag_v", {31'b0, flag_v}, {31'b0, e.v});
          chk("R11", "flag_c", {31'b0, flag_c}, 32'd0);
          last_lo = lo_word;
        end
      end
      prev_done = done;
    end
  end

  initial begin
    logic [31:0] lo_s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "start_ready", {31'b0, start_ready}, 32'd1);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "we", {30'b0, lo_we, hi_we}, 32'd0);
    chk("R1", "flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    chk("R1", "lo_word", lo_word, 32'd0);
    chk("R1", "hi_word", hi_word, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 no acceptance without start_valid
    chk("R2", "no done when idle", {31'b0, done}, 32'd0);

    // Short unsigned (R7, R9)
    run_op(0, 0, 1, 32'd7, 32'd6, 0);
    run_op(0, 0, 1, 32'h0001_0000, 32'h0001_0000, 0);   // low zero, overflow
    run_op(0, 0, 1, 32'hFFFF_FFFF, 32'd1, 0);           // N set, no overflow
    run_op(0, 0, 1, 32'hFFFF_FFFF, 32'd2, 0);
    // Short signed (R8, R5)
    run_op(0, 1, 1, 32'hFFFF_FFFF, 32'd5, 0);
    run_op(0, 1, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);   // overflows
    run_op(0, 1, 1, 32'h8000_0000, 32'd1, 0);           // fits
    run_op(0, 1, 1, 32'h0001_0000, 32'hFFFF_0000, 0);
    run_op(0, 1, 1, 32'd0, 32'hFFFF_FFFB, 0);
    // Overflow reporting off (R10)
    run_op(0, 1, 0, 32'h8765_4321, 32'hF0F0_1234, 0);
    lo_s = last_lo;
    run_op(0, 0, 0, 32'h8765_4321, 32'hF0F0_1234, 0);
    chk("R10", "lo signed vs unsigned", last_lo, lo_s);
    // Long forms (R4, R6)
    run_op(1, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_op(1, 1, 1, 32'hFFFF_FFFF, 32'd3, 0);
    run_op(1, 1, 0, 32'h8000_0000, 32'h8000_0000, 0);
    run_op(1, 0, 1, 32'h0001_0000, 32'h0001_0000, 0);   // low zero, Z clear
    run_op(1, 1, 1, 32'd0, 32'h8000_0000, 0);           // all zero
    // Short after long: hi_we stays low (R4)
    run_op(0, 0, 1, 32'd3, 32'd3, 0);
    // Busy requests ignored (R2)
    run_op(0, 1, 1, 32'h0000_1234, 32'hFFFF_FF00, 1);
    run_op(1, 0, 0, 32'hABCD_0001, 32'h0000_0010, 1);
    repeat (40) @(negedge clk);
    chk("R2", "no stray results", {31'b0, done}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule